// File: doc/BRIEF.md
# H-Bridge Gate Sequencer for a DC Motor

The block is a synchronous controller for the four switches of an H-bridge that drives a brushed DC motor. Each clock it reads four synchronous control levels: direction, drive enable, decay select and an active-low sleep request. It also reads a fault flag and a flag that says the load current has reached zero. From these it produces one enable for each of the four gates (high and low side of leg A and of leg B) and a per-leg indication that the leg is floating. Speed comes from an outside PWM source toggling the drive enable. The block works out the target state of each leg and sequences the gates so that the two switches of one leg are never on together. Any switch is released at the next clock edge. A switch is turned on only after a programmable dead time.

A supervisor state machine gates all switching. Its states are `SV_POWERUP`, `SV_RUN`, `SV_FAULT`, `SV_SLEEP` and `SV_WAKE`, with these transitions:
- out of reset it counts a power-up holdoff (POWERUP→RUN, or →FAULT if a fault is present when the count ends);
- a sleep request from any state goes to SLEEP;
- release of sleep goes to WAKE, which counts the wake holdoff and then moves to RUN or FAULT;
- RUN→FAULT on a fault, and FAULT→RUN once the fault clears.

Each leg has its own sequencer with the states `LG_OFF`, `LG_ARM_HI`, `LG_ARM_LO`, `LG_HI` and `LG_LO`:
- an arming state counts the dead time before the gate it names is switched on;
- any change of request leaves an on-state at once, to OFF or to the other arming state.

In fast decay, a zero-current report floats both legs. That report is latched until direction changes or the bridge leaves fast decay. The latch stops the current from reversing.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: With sleep_n_i=1, enable_i=1 and no fault, phase_i=1 settles to gate_ah_o=1, gate_bl_o=1 and the other gates at 0. phase_i=0 settles to gate_al_o=1, gate_bh_o=1 and the other gates at 0. mode_i has no effect in either case.
- R2: With sleep_n_i=1, enable_i=0 and mode_i=1, the bridge settles to both low-side gates on and both high-side gates off, whatever phase_i is.
- R3: With sleep_n_i=1, enable_i=0 and mode_i=0 (fast decay), phase_i=1 settles to gate_al_o=1 and gate_bh_o=1. phase_i=0 settles to gate_ah_o=1 and gate_bl_o=1.
- R4: In fast decay, zero_i=1 turns all four gates off at the next clock edge. The bridge stays off after zero_i falls, until phase_i changes or the bridge leaves fast decay.
- R5: sleep_n_i=0 turns all four gates off at the next clock edge, whatever the other inputs are.
- R6: After sleep_n_i rises, no gate turns on for WAKE_CYC cycles. Normal drive returns within WAKE_CYC+DEAD_CYC+3 cycles.
- R7: After reset is released, no gate turns on for PWRUP_CYC cycles.
- R8: fault_i=1 turns all gates off at the next clock edge. The gates stay off while fault_i is held. Drive resumes after fault_i clears, once the dead time has passed.
- R9: A gate turns on exactly DEAD_CYC+1 clock edges after the edge that first sees its request. It turns on only when the other gate of its leg has been off for at least DEAD_CYC+1 sampled cycles. The high and low gates of a leg are never on together.
- R10: A gate whose request is withdrawn turns off at the first clock edge after the change.
- R11: hiz_a_o (hiz_b_o) is 1 exactly when both gates of leg A (leg B) are off. In reset all gates are 0 and both hiz outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_i | input | 1 | Direction select |
| enable_i | input | 1 | Drive enable (external PWM) |
| mode_i | input | 1 | Decay select when not enabled: 1 slow (brake), 0 fast |
| sleep_n_i | input | 1 | Active-low sleep request |
| fault_i | input | 1 | Combined over-temperature / supply undervoltage fault |
| zero_i | input | 1 | Load current has reached zero |
| gate_ah_o | output | 1 | Leg A high-side gate enable |
| gate_al_o | output | 1 | Leg A low-side gate enable |
| gate_bh_o | output | 1 | Leg B high-side gate enable |
| gate_bl_o | output | 1 | Leg B low-side gate enable |
| hiz_a_o | output | 1 | Leg A floating |
| hiz_b_o | output | 1 | Leg B floating |

## Verification
The hardest case to reach from the ports is the latched zero-current float. It needs a zero report during fast decay, held off after the report ends, and then cleared by two different exits. Directed stimulus first settles fast decay and pulses zero_i for one cycle. It then confirms the float persists, flips phase_i to start a new episode, and floats the bridge again. Next it passes through slow decay and back, to show the latch was dropped. Random phase, enable and decay patterns surround these tests. A sampling monitor measures the gap before every gate turn-on.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    localparam int unsigned NUM_LEGS = 2;

    typedef enum logic [1:0] {
        DRV_OFF = 2'd0,
        DRV_HI  = 2'd1,
        DRV_LO  = 2'd2
    } drive_t;

    typedef enum logic [2:0] {
        SV_POWERUP = 3'd0,
        SV_RUN     = 3'd1,
        SV_FAULT   = 3'd2,
        SV_SLEEP   = 3'd3,
        SV_WAKE    = 3'd4
    } sv_state_t;

    typedef enum logic [2:0] {
        LG_OFF    = 3'd0,
        LG_ARM_HI = 3'd1,
        LG_ARM_LO = 3'd2,
        LG_HI     = 3'd3,
        LG_LO     = 3'd4
    } leg_state_t;

    // Convert a duration in ns to clock cycles, rounding up, at least one.
    function automatic int unsigned ns_to_cyc(int unsigned hz, int unsigned ns);
        longint unsigned prod;
        longint unsigned cyc;
        prod = longint'(hz) * longint'(ns);
        cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
        if (cyc == 0) cyc = 1;
        return int'(cyc[31:0]);
    endfunction

endpackage

// File: rtl/hbg_supervisor.sv
module hbg_supervisor
    import hbg_pkg::*;
#(
    parameter int unsigned PWRUP_CYC = 10000,
    parameter int unsigned WAKE_CYC  = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_n_i,
    input  logic fault_i,
    output logic run_ok_o
);

    localparam int unsigned MAX_CYC = (PWRUP_CYC > WAKE_CYC) ? PWRUP_CYC : WAKE_CYC;
    localparam int unsigned CW      = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] PW_LAST = CW'(PWRUP_CYC - 1);
    localparam logic [CW-1:0] WK_LAST = CW'(WAKE_CYC - 1);

    sv_state_t     st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= SV_POWERUP;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            SV_POWERUP: begin
                if (!sleep_n_i)          st_nx = SV_SLEEP;
                else if (cnt == PW_LAST) st_nx = fault_i ? SV_FAULT : SV_RUN;
            end
            SV_RUN: begin
                if (!sleep_n_i)   st_nx = SV_SLEEP;
                else if (fault_i) st_nx = SV_FAULT;
            end
            SV_FAULT: begin
                if (!sleep_n_i)    st_nx = SV_SLEEP;
                else if (!fault_i) st_nx = SV_RUN;
            end
            SV_SLEEP: begin
                if (sleep_n_i) st_nx = SV_WAKE;
            end
            SV_WAKE: begin
                if (!sleep_n_i)          st_nx = SV_SLEEP;
                else if (cnt == WK_LAST) st_nx = fault_i ? SV_FAULT : SV_RUN;
            end
            default: st_nx = SV_POWERUP;
        endcase

        if (st_nx != st)
            cnt_nx = '0;
        else if (st == SV_POWERUP || st == SV_WAKE)
            cnt_nx = cnt + 1'b1;
        else
            cnt_nx = '0;
    end

    always_comb begin
        run_ok_o = (st == SV_RUN) && sleep_n_i && !fault_i;
    end

    // R6
    wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_n_i) |=> !run_ok_o);

endmodule

// File: rtl/hbg_decode.sv
module hbg_decode
    import hbg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   phase_i,
    input  logic   enable_i,
    input  logic   mode_i,
    input  logic   sleep_n_i,
    input  logic   zero_i,
    output drive_t tgt_a_o,
    output drive_t tgt_b_o
);

    logic phase_q;
    logic zl_q;
    logic fast;
    logic phase_chg;
    logic float_now;

    always_comb begin
        fast      = sleep_n_i && !enable_i && !mode_i;
        phase_chg = phase_i != phase_q;
        float_now = fast && (zero_i || (zl_q && !phase_chg));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            zl_q    <= 1'b0;
        end else begin
            phase_q <= phase_i;
            zl_q    <= float_now;
        end
    end

    always_comb begin
        tgt_a_o = DRV_OFF;
        tgt_b_o = DRV_OFF;
        if (!sleep_n_i || float_now) begin
            tgt_a_o = DRV_OFF;
            tgt_b_o = DRV_OFF;
        end else if (enable_i) begin
            tgt_a_o = phase_i ? DRV_HI : DRV_LO;
            tgt_b_o = phase_i ? DRV_LO : DRV_HI;
        end else if (mode_i) begin
            tgt_a_o = DRV_LO;
            tgt_b_o = DRV_LO;
        end else begin
            tgt_a_o = phase_i ? DRV_LO : DRV_HI;
            tgt_b_o = phase_i ? DRV_HI : DRV_LO;
        end
    end

    // R4
    zero_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fast && zero_i) |-> (tgt_a_o == DRV_OFF && tgt_b_o == DRV_OFF));

endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
    import hbg_pkg::*;
#(
    parameter int unsigned DEAD_CYC = 25
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   permit_i,
    input  drive_t target_i,
    output logic   gh_o,
    output logic   gl_o
);

    localparam int unsigned DW = $clog2(DEAD_CYC + 1);
    localparam logic [DW-1:0] DEAD_LAST = DW'(DEAD_CYC - 1);

    leg_state_t    st, st_nx;
    logic [DW-1:0] cnt, cnt_nx;
    drive_t        want;

    always_comb begin
        want = permit_i ? target_i : DRV_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= LG_OFF;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            LG_OFF: begin
                if (want == DRV_HI)      st_nx = LG_ARM_HI;
                else if (want == DRV_LO) st_nx = LG_ARM_LO;
            end
            LG_ARM_HI: begin
                if (want == DRV_HI)      st_nx = (cnt == DEAD_LAST) ? LG_HI : LG_ARM_HI;
                else if (want == DRV_LO) st_nx = LG_ARM_LO;
                else                     st_nx = LG_OFF;
            end
            LG_ARM_LO: begin
                if (want == DRV_LO)      st_nx = (cnt == DEAD_LAST) ? LG_LO : LG_ARM_LO;
                else if (want == DRV_HI) st_nx = LG_ARM_HI;
                else                     st_nx = LG_OFF;
            end
            LG_HI: begin
                if (want == DRV_LO)       st_nx = LG_ARM_LO;
                else if (want != DRV_HI)  st_nx = LG_OFF;
            end
            LG_LO: begin
                if (want == DRV_HI)       st_nx = LG_ARM_HI;
                else if (want != DRV_LO)  st_nx = LG_OFF;
            end
            default: st_nx = LG_OFF;
        endcase

        if (st_nx != st)
            cnt_nx = '0;
        else if (st == LG_ARM_HI || st == LG_ARM_LO)
            cnt_nx = cnt + 1'b1;
        else
            cnt_nx = '0;
    end

    always_comb begin
        gh_o = (st == LG_HI);
        gl_o = (st == LG_LO);
    end

    // R10
    off_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !permit_i |=> (!gh_o && !gl_o));

    // R9
    hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gh_o) |-> $past(!gl_o));

    // R9
    lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gl_o) |-> $past(!gh_o));

endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
    import hbg_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 50_000_000,
    parameter int unsigned DEAD_NS  = 500,
    parameter int unsigned PWRUP_NS = 200_000,
    parameter int unsigned WAKE_NS  = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_i,
    input  logic enable_i,
    input  logic mode_i,
    input  logic sleep_n_i,
    input  logic fault_i,
    input  logic zero_i,
    output logic gate_ah_o,
    output logic gate_al_o,
    output logic gate_bh_o,
    output logic gate_bl_o,
    output logic hiz_a_o,
    output logic hiz_b_o
);

    localparam int unsigned DEAD_CYC  = ns_to_cyc(CLK_HZ, DEAD_NS);
    localparam int unsigned PWRUP_CYC = ns_to_cyc(CLK_HZ, PWRUP_NS);
    localparam int unsigned WAKE_CYC  = ns_to_cyc(CLK_HZ, WAKE_NS);

    logic   run_ok;
    drive_t tgt [NUM_LEGS];
    logic   gh  [NUM_LEGS];
    logic   gl  [NUM_LEGS];

    hbg_supervisor #(
        .PWRUP_CYC (PWRUP_CYC),
        .WAKE_CYC  (WAKE_CYC)
    ) u_sup (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_n_i (sleep_n_i),
        .fault_i   (fault_i),
        .run_ok_o  (run_ok)
    );

    hbg_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_i   (phase_i),
        .enable_i  (enable_i),
        .mode_i    (mode_i),
        .sleep_n_i (sleep_n_i),
        .zero_i    (zero_i),
        .tgt_a_o   (tgt[0]),
        .tgt_b_o   (tgt[1])
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        hbg_leg #(
            .DEAD_CYC (DEAD_CYC)
        ) u_leg (
            .clk      (clk),
            .rst_n    (rst_n),
            .permit_i (run_ok),
            .target_i (tgt[g]),
            .gh_o     (gh[g]),
            .gl_o     (gl[g])
        );
    end

    always_comb begin
        gate_ah_o = gh[0];
        gate_al_o = gl[0];
        gate_bh_o = gh[1];
        gate_bl_o = gl[1];
        hiz_a_o   = !gh[0] && !gl[0];
        hiz_b_o   = !gh[1] && !gl[1];
    end

    // R9
    no_shoot_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_ah_o && gate_al_o));

    // R9
    no_shoot_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_bh_o && gate_bl_o));

    // R5
    sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_n_i |=> !(gate_ah_o || gate_al_o || gate_bh_o || gate_bl_o));

    // R8
    fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i |=> !(gate_ah_o || gate_al_o || gate_bh_o || gate_bl_o));

endmodule

// File: tb/hbridge_gate_ctrl_tb.sv
module hbridge_gate_ctrl_tb;

    localparam int DEAD = 8;    // 40 ns at 200 MHz
    localparam int PW   = 60;   // 300 ns
    localparam int WK   = 100;  // 500 ns

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic phase = 1'b1, enable = 1'b1, mode = 1'b0, sleep_n = 1'b1, fault = 1'b0, zero = 1'b0;
    logic ah, al, bh, bl, hza, hzb;

    int checks = 0;
    int failures = 0;
    int viol = 0;
    int run_al = 0, run_ah = 0, run_bl = 0, run_bh = 0;
    logic pah = 0, pal = 0, pbh = 0, pbl = 0;

    always #2.5 clk = ~clk;

    hbridge_gate_ctrl #(
        .CLK_HZ   (200_000_000),
        .DEAD_NS  (40),
        .PWRUP_NS (300),
        .WAKE_NS  (500)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_i   (phase),
        .enable_i  (enable),
        .mode_i    (mode),
        .sleep_n_i (sleep_n),
        .fault_i   (fault),
        .zero_i    (zero),
        .gate_ah_o (ah),
        .gate_al_o (al),
        .gate_bh_o (bh),
        .gate_bl_o (bl),
        .hiz_a_o   (hza),
        .hiz_b_o   (hzb)
    );

    // Expected settled outputs {ah,al,bh,bl,hza,hzb} while awake, fault-free, no zero latch.
    function automatic logic [5:0] exp_out(logic ph, logic en, logic md);
        if (en)       return ph ? 6'b100100 : 6'b011000;
        else if (md)  return 6'b010100;
        else          return ph ? 6'b011000 : 6'b100100;
    endfunction

    localparam logic [5:0] ALL_OFF = 6'b000011;

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_vec(string req, logic [5:0] exp);
        logic [5:0] act;
        act = {ah, al, bh, bl, hza, hzb};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic check_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    // R9 gap monitor: a gate may rise only after the opposite gate was off DEAD+1 samples.
    always @(negedge clk) begin
        if (rst_n) begin
            run_al = al ? 0 : run_al + 1;
            run_ah = ah ? 0 : run_ah + 1;
            run_bl = bl ? 0 : run_bl + 1;
            run_bh = bh ? 0 : run_bh + 1;
            if (ah && !pah && run_al < DEAD + 1) viol++;
            if (al && !pal && run_ah < DEAD + 1) viol++;
            if (bh && !pbh && run_bl < DEAD + 1) viol++;
            if (bl && !pbl && run_bh < DEAD + 1) viol++;
            if ((ah && al) || (bh && bl)) viol++;
            pah = ah; pal = al; pbh = bh; pbl = bl;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        cyc(3);
        // R11 reset state
        check_vec("R11 reset", ALL_OFF);
        rst_n = 1'b1;

        // R7 power-up holdoff with forward request
        cyc(PW);
        check_vec("R7 holdoff", ALL_OFF);
        cyc(DEAD + 3);
        check_vec("R1 forward after powerup", exp_out(1, 1, 0));

        // R10 / R9 exact timing: forward -> brake
        enable = 1'b0; mode = 1'b1;
        cyc(1);
        check_bit("R10 ah off", ah, 1'b0);
        check_bit("R10 al not yet", al, 1'b0);
        cyc(DEAD - 1);
        check_bit("R9 al still off", al, 1'b0);
        cyc(1);
        check_bit("R9 al on at DEAD+1", al, 1'b1);
        check_vec("R2 brake", exp_out(0, 0, 1));

        // R4 zero latch in fast decay
        phase = 1'b1; enable = 1'b0; mode = 1'b0;
        cyc(DEAD + 3);
        check_vec("R3 fast phase1", exp_out(1, 0, 0));
        zero = 1'b1;
        cyc(1);
        zero = 1'b0;
        check_vec("R4 float now", ALL_OFF);
        cyc(20);
        check_vec("R4 float held", ALL_OFF);
        phase = 1'b0;
        cyc(DEAD + 3);
        check_vec("R4 phase change clears", exp_out(0, 0, 0));
        zero = 1'b1;
        cyc(1);
        zero = 1'b0;
        check_vec("R4 float again", ALL_OFF);
        mode = 1'b1;
        cyc(DEAD + 3);
        check_vec("R2 brake after float", exp_out(0, 0, 1));
        mode = 1'b0;
        cyc(DEAD + 3);
        check_vec("R4 latch dropped on exit", exp_out(0, 0, 0));

        // R8 fault
        phase = 1'b1; enable = 1'b1;
        cyc(DEAD + 3);
        check_vec("R1 forward", exp_out(1, 1, 0));
        fault = 1'b1;
        cyc(1);
        check_vec("R8 fault off", ALL_OFF);
        cyc(10);
        check_vec("R8 fault held", ALL_OFF);
        fault = 1'b0;
        cyc(DEAD + 3);
        check_vec("R8 resume", exp_out(1, 1, 0));

        // R5 / R6 sleep and wake
        sleep_n = 1'b0;
        cyc(1);
        check_vec("R5 sleep off", ALL_OFF);
        cyc(15);
        check_vec("R5 sleep held", ALL_OFF);
        sleep_n = 1'b1;
        cyc(WK);
        check_vec("R6 wake holdoff", ALL_OFF);
        cyc(DEAD + 3);
        check_vec("R6 drive after wake", exp_out(1, 1, 0));

        // Random patterns: R1 R2 R3 R11
        for (int i = 0; i < 400; i++) begin
            logic ph, en, md;
            ph = 1'($urandom);
            en = 1'($urandom);
            md = 1'($urandom);
            phase = ph; enable = en; mode = md;
            cyc(DEAD + 3);
            check_vec(en ? "R1 random" : (md ? "R2 random" : "R3 random"), exp_out(ph, en, md));
        end

        // R9 monitor result
        checks++;
        if (viol != 0) begin
            failures++;
            $display("FAIL R9 gap violations act=%0d exp=0", viol);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule